// File: doc/BRIEF.md
# Load Address Index Register Unit

This unit carries out a load-address operation on a bank of two 16-bit index registers. Each register is kept as a high byte and a low byte in a byte-wide local store, and every update passes through one 8-bit adder, one byte per clock. A start strobe brings in the instruction length, the modifier (Q) byte, the op code and two operand bytes. The unit then runs a fixed two-step sequence and pulses `done` after the last byte write.

The long (four-byte) form writes an immediate. The first operand byte goes into the high half in the first step, and the second operand byte goes into the low half in the second step. The short (three-byte) form uses only `opnd_lo` as an unsigned displacement. It adds the displacement to the low byte of a base register and saves the carry. In the next step it adds that carry to the base high byte. The modifier byte chooses the destination. The op code chooses the base, independently of the destination.

Top module: `lai_unit`

## Requirements
- R1: While `rst` is high, and on the cycle after it, `xr1` and `xr2` read 0 and `busy` and `done` are low.
- R2: `q_code[0]` makes XR1 a destination and `q_code[1]` makes XR2 a destination. With both bits set, both registers receive the same value.
- R3: With `q_code[1:0]` = 00, neither register changes, yet the sequence runs and `done` still pulses.
- R4: With `long_form` = 1, the destination becomes `{opnd_hi, opnd_lo}`.
- R5: With `long_form` = 0, the destination becomes base + zero-extended `opnd_lo`, modulo 2^16. A carry out of the low byte increments the high byte, and 0xFFFF wraps through 0.
- R6: The base is decoded from `op_code[7:4]`: 4'h1 selects XR1, 4'h2 selects XR2, and any other value selects a base of zero.
- R7: The base choice is independent of the destination choice. When base and destination are the same register, the sum uses its old value.
- R8: A start accepted on edge k raises `busy` for the two cycles after it. Both byte writes complete by edge k+2, and `done` is high for exactly the one cycle after edge k+2.
- R9: A `start` asserted while `busy` is high is ignored: the operation in flight produces its own result and only one `done` pulse.
- R10: While the unit is idle, neither register changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (sampled when idle) |
| long_form | input | 1 | 1 = immediate form, 0 = indexed form |
| q_code | input | 8 | Modifier byte; bits [1:0] select destinations |
| op_code | input | 8 | Op code; bits [7:4] select the base register |
| opnd_hi | input | 8 | First operand byte (immediate high byte) |
| opnd_lo | input | 8 | Last operand byte (immediate low byte or displacement) |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle pulse after the final byte write |
| xr1 | output | 16 | Index register 1 contents |
| xr2 | output | 16 | Index register 2 contents |

## Verification
The checker watches the timing on every cycle. It checks the single-cycle `done` pulse that follows two busy cycles, the acceptance of a start when the unit is idle, the hold of both registers while idle or when no destination is selected, and the reset state. Register values depend on the data, so they are shown only by the bench scenarios. These compare both registers after each operation with a 16-bit reference model, covering low-byte carry, wrap past 0xFFFF, a zero base, a base equal to the destination, both destinations at once, and a start issued while busy.

// File: rtl/lai_pkg.sv
package lai_pkg;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 2 * BYTE_W;
    localparam int NUM_XR = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DHI,   // direct form, high byte
        ST_DLO,   // direct form, low byte
        ST_XLO,   // indexed form, low byte + carry capture
        ST_XHI    // indexed form, high byte + carry
    } lai_state_e;

    typedef struct packed {
        logic                    long_form;
        logic [NUM_XR-1:0]       dest;   // one bit per destination register
        logic [NUM_XR-1:0]       base;   // one-hot base, zero = no base
        logic [BYTE_W-1:0]       hi;
        logic [BYTE_W-1:0]       lo;
    } lai_cmd_t;

    function automatic logic [NUM_XR-1:0] dest_decode(input logic [BYTE_W-1:0] q);
        return q[NUM_XR-1:0];
    endfunction

    function automatic logic [NUM_XR-1:0] base_decode(input logic [BYTE_W-1:0] op);
        logic [NUM_XR-1:0] sel;
        sel = '0;
        for (int i = 0; i < NUM_XR; i++) begin
            if (op[BYTE_W-1 -: 4] == 4'(i + 1)) sel[i] = 1'b1;
        end
        return sel;
    endfunction
endpackage

// File: rtl/lai_bytealu.sv
module lai_bytealu #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout
);
    logic [W:0] full;
    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
        sum  = full[W-1:0];
        cout = full[W];
    end
endmodule

// File: rtl/lai_lsr.sv
module lai_lsr #(
    parameter int W = 8,
    parameter int N = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [N-1:0]          wr_sel,
    input  logic                  wr_hi,
    input  logic                  wr_lo,
    input  logic [W-1:0]          wdata,
    output logic [N-1:0][2*W-1:0] rd
);
    for (genvar g = 0; g < N; g++) begin : g_xr
        logic [W-1:0] hi_q;
        logic [W-1:0] lo_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                hi_q <= '0;
                lo_q <= '0;
            end else begin
                if (wr_sel[g] && wr_hi) hi_q <= wdata;
                if (wr_sel[g] && wr_lo) lo_q <= wdata;
            end
        end
        assign rd[g] = {hi_q, lo_q};
    end
endmodule

// File: rtl/lai_seq.sv
module lai_seq
    import lai_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  lai_cmd_t   cmd_in,
    output lai_state_e state,
    output lai_cmd_t   cmd,
    output logic       done
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cmd   <= '0;
            done  <= 1'b0;
        end else begin
            done <= (state == ST_DLO) || (state == ST_XHI);
            unique case (state)
                ST_IDLE: if (start) begin
                    cmd   <= cmd_in;
                    state <= cmd_in.long_form ? ST_DHI : ST_XLO;
                end
                ST_DHI:  state <= ST_DLO;
                ST_DLO:  state <= ST_IDLE;
                ST_XLO:  state <= ST_XHI;
                ST_XHI:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lai_unit.sv
module lai_unit
    import lai_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        long_form,
    input  logic [7:0]  q_code,
    input  logic [7:0]  op_code,
    input  logic [7:0]  opnd_hi,
    input  logic [7:0]  opnd_lo,
    output logic        busy,
    output logic        done,
    output logic [15:0] xr1,
    output logic [15:0] xr2
);
    lai_state_e                    state;
    lai_cmd_t                      cmd_in, cmd;
    logic [NUM_XR-1:0][WORD_W-1:0] rd;
    logic [WORD_W-1:0]             base_val;
    logic [BYTE_W-1:0]             alu_a, alu_b, alu_sum;
    logic                          alu_cin, alu_cout, carry_q;
    logic                          wr_hi, wr_lo;

    always_comb begin
        cmd_in.long_form = long_form;
        cmd_in.dest      = dest_decode(q_code);
        cmd_in.base      = base_decode(op_code);
        cmd_in.hi        = opnd_hi;
        cmd_in.lo        = opnd_lo;
    end

    lai_seq u_seq (
        .clk(clk), .rst(rst), .start(start), .cmd_in(cmd_in),
        .state(state), .cmd(cmd), .done(done)
    );

    always_comb begin
        base_val = '0;
        for (int i = 0; i < NUM_XR; i++) begin
            if (cmd.base[i]) base_val = rd[i];
        end
    end

    always_comb begin
        alu_a   = '0;
        alu_b   = '0;
        alu_cin = 1'b0;
        wr_hi   = 1'b0;
        wr_lo   = 1'b0;
        unique case (state)
            ST_DHI: begin alu_b = cmd.hi; wr_hi = 1'b1; end
            ST_DLO: begin alu_b = cmd.lo; wr_lo = 1'b1; end
            ST_XLO: begin
                alu_a = base_val[BYTE_W-1:0];
                alu_b = cmd.lo;
                wr_lo = 1'b1;
            end
            ST_XHI: begin
                alu_a   = base_val[WORD_W-1:BYTE_W];
                alu_cin = carry_q;
                wr_hi   = 1'b1;
            end
            default: ;
        endcase
    end

    lai_bytealu #(.W(BYTE_W)) u_alu (
        .a(alu_a), .b(alu_b), .cin(alu_cin), .sum(alu_sum), .cout(alu_cout)
    );

    always_ff @(posedge clk) begin
        if (rst)                   carry_q <= 1'b0;
        else if (state == ST_XLO)  carry_q <= alu_cout;
    end

    lai_lsr #(.W(BYTE_W), .N(NUM_XR)) u_lsr (
        .clk(clk), .rst(rst), .wr_sel(cmd.dest), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wdata(alu_sum), .rd(rd)
    );

    assign busy = (state != ST_IDLE);
    assign xr1  = rd[0];
    assign xr2  = rd[1];
endmodule

// File: rtl/lai_unit_chk.sv
module lai_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic [7:0]  q_code,
    input logic [15:0] xr1,
    input logic [15:0] xr2
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (xr1 == 16'h0 && xr2 == 16'h0 && !busy && !done));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_after_two_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy) && $past(busy, 2)));

    // R8
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |=> ($stable(xr1) && $stable(xr2)));

    // R3
    no_dest_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && q_code[1:0] == 2'b00)
        |=> ($stable(xr1) && $stable(xr2)) ##1 ($stable(xr1) && $stable(xr2))
            ##1 ($stable(xr1) && $stable(xr2) && done));
endmodule

bind lai_unit lai_unit_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
    .q_code(q_code), .xr1(xr1), .xr2(xr2)
);

// File: tb/lai_unit_tb.sv
`timescale 1ns/1ps
module lai_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        start, long_form;
    logic [7:0]  q_code, op_code, opnd_hi, opnd_lo;
    logic        busy, done;
    logic [15:0] xr1, xr2;
    int          total = 0;
    int          bad   = 0;
    logic [15:0] m1 = 16'h0, m2 = 16'h0;

    always #2 clk = ~clk;

    lai_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .long_form(long_form),
        .q_code(q_code), .op_code(op_code), .opnd_hi(opnd_hi), .opnd_lo(opnd_lo),
        .busy(busy), .done(done), .xr1(xr1), .xr2(xr2)
    );

    // {long_form, q_code, op_code, opnd_hi, opnd_lo}
    localparam logic [32:0] VEC [8] = '{
        {1'b1, 8'h01, 8'h00, 8'h12, 8'h34},  // R4 R2 immediate into XR1
        {1'b1, 8'h02, 8'h00, 8'hFF, 8'hF0},  // R4 R2 immediate into XR2
        {1'b0, 8'h01, 8'h20, 8'h00, 8'h20},  // R5 R7 XR2 base, wrap past FFFF
        {1'b0, 8'h02, 8'h10, 8'h00, 8'hF5},  // R5 R6 XR1 base, low carry
        {1'b0, 8'h03, 8'h50, 8'h00, 8'h7F},  // R6 zero base, R2 both dests
        {1'b1, 8'h00, 8'h00, 8'hAB, 8'hCD},  // R3 no destination
        {1'b0, 8'h01, 8'h10, 8'h00, 8'h81},  // R7 base equals destination
        {1'b0, 8'hFC, 8'hF0, 8'h00, 8'h01}   // R3 high Q bits ignored
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] model_val(input logic lf, input logic [7:0] op,
                                              input logic [7:0] hi, input logic [7:0] lo);
        logic [15:0] base;
        if (lf) return {hi, lo};
        base = (op[7:4] == 4'h1) ? m1 : (op[7:4] == 4'h2) ? m2 : 16'h0;
        return base + {8'h00, lo};
    endfunction

    task automatic run_op(input logic [32:0] v, input bit poke, input string req);
        logic [15:0] val;
        val = model_val(v[32], v[23:16], v[15:8], v[7:0]);
        @(negedge clk);
        {long_form, q_code, op_code, opnd_hi, opnd_lo} = v;
        start = 1'b1;
        @(negedge clk);
        start = poke;   // R9: extra start while busy
        if (poke) begin
            long_form = 1'b1; q_code = 8'h03; opnd_hi = 8'h5A; opnd_lo = 8'hA5;
        end
        check({req, " R8 busy step1"}, {31'b0, busy}, 32'd1);
        check({req, " R8 done step1"}, {31'b0, done}, 32'd0);
        @(negedge clk);
        start = 1'b0;
        check({req, " R8 busy step2"}, {31'b0, busy}, 32'd1);
        @(negedge clk);
        check({req, " R8 done pulse"}, {31'b0, done}, 32'd1);
        check({req, " R8 idle after"}, {31'b0, busy}, 32'd0);
        if (v[24]) m1 = val;
        if (v[25]) m2 = val;
        check({req, " xr1"}, {16'b0, xr1}, {16'b0, m1});
        check({req, " xr2"}, {16'b0, xr2}, {16'b0, m2});
        @(negedge clk);
        check({req, " R8 done single"}, {31'b0, done}, 32'd0);
        check({req, " R9 no extra run"}, {31'b0, busy}, 32'd0);
    endtask

    initial begin
        rst = 1'b1; start = 1'b0; long_form = 1'b0;
        q_code = '0; op_code = '0; opnd_hi = '0; opnd_lo = '0;
        repeat (3) @(negedge clk);
        check("R1 xr1 reset", {16'b0, xr1}, 32'h0);
        check("R1 xr2 reset", {16'b0, xr2}, 32'h0);
        check("R1 busy reset", {31'b0, busy}, 32'd0);
        check("R1 done reset", {31'b0, done}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < 8; i++) run_op(VEC[i], 1'b0, "R2 R4 R5 vector");

        // R9: start held during an indexed run
        run_op({1'b0, 8'h02, 8'h20, 8'h00, 8'hFF}, 1'b1, "R9 ignored start");
        // R5 wrap: XR1 = FFFF then +1
        run_op({1'b1, 8'h01, 8'h00, 8'hFF, 8'hFF}, 1'b0, "R5 set FFFF");
        run_op({1'b0, 8'h01, 8'h10, 8'h00, 8'h01}, 1'b0, "R5 FFFF wrap");
        check("R5 wrap value", {16'b0, xr1}, 32'h0);

        // R10: idle hold with inputs toggling and no start
        @(negedge clk);
        q_code = 8'h03; opnd_hi = 8'h77; opnd_lo = 8'h88; long_form = 1'b1;
        repeat (4) @(negedge clk);
        check("R10 xr1 idle", {16'b0, xr1}, {16'b0, m1});
        check("R10 xr2 idle", {16'b0, xr2}, {16'b0, m2});

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule